// File: doc/BRIEF.md
# Programmable-Format Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output pin. The host reaches it through a small register bus. That bus has an address, write data, read data, and single-cycle write and read strobes. The host loads a byte into a one-deep holding register. From there the byte moves into a shift register and goes out as a start bit, five to eight data bits, an optional parity bit, and one, one-and-a-half or two stop bits.

The frame shape comes from a format register that the host can write and read back. The same register also holds a line-break control and a bank-select bit. The bank-select bit turns the two lowest offsets into the two bytes of a 16-bit rate divisor. The divisor sets how many clock cycles lie between oversampling ticks, and every bit lasts sixteen ticks.

A host that streams data polls the `thr_empty` output. It writes the next byte whenever that flag is high. Because of the holding register, frames go out back to back.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `thr_empty` is 1, the format register at offset 3 reads 0x00, and both divisor bytes read 0x00.
- R2: Each frame starts with exactly one start bit at 0. Data bits follow, least significant bit first. While no frame is in progress, `tx_line` rests at 1.
- R3: Format bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. The format is captured when a byte enters the shift register.
- R4: When format bit 2 is 0, a frame has one stop bit of 16 ticks. When bit 2 is 1, a frame has 24 ticks of stop with 5 data bits, and 32 ticks with 6, 7 or 8 data bits. Stop bits are 1.
- R5: When format bit 3 is 1, a parity bit is sent after the last data bit. If bit 4 is 1, the parity bit is the XOR of the data bits (even parity). If bit 4 is 0, it is the inverse of that XOR (odd parity).
- R6: While format bit 6 is 1, `tx_line` is 0. The frame in progress keeps advancing in the background.
- R7: Offset 3 reads back the last value written to it, all eight bits.
- R8: While format bit 7 is 1, offsets 0 and 1 write and read the low and high divisor bytes. A write to offset 0 then leaves the holding register and `thr_empty` unchanged.
- R9: With divisor N > 0, a tick occurs every N cycles and each start, data and parity bit lasts 16 ticks. With divisor 0, no tick occurs and the line holds its current bit.
- R10: A write to offset 0 with bit 7 clear fills the holding register and clears `thr_empty`. The flag rises in the cycle after the byte moves into the shift register. If the host writes in the same cycle as that move, the old byte is sent, the new byte is kept, and the flag stays 0.
- R11: When a second byte is already waiting as a frame ends, the next start bit begins 1 cycle after the last stop tick. With divisor 1, the distance from one start to the next is 16·(1 + data bits + parity) + stop ticks + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| reg_rdata | output | 8 | Read data, 0 when reg_rd is low |
| thr_empty | output | 1 | Holding register can take a new byte |
| tx_line | output | 1 | Serial output |

## Verification
Two events can land in the same clock edge. In one, the holding register hands its byte to the shift register. In the other, the host writes a new byte into the holding register. The bench provokes this by writing two bytes on consecutive cycles into an idle transmitter. The second write then lands exactly on the transfer edge. The test is judged in three places: the flag must stay low right after that edge, both bytes must appear on the line in order, and the two start bits must lie exactly one frame length plus one cycle apart.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;

  // Format register layout (bit 7 down to bit 0)
  typedef struct packed {
    logic       bank_div;   // 7: offsets 0/1 reach divisor bytes
    logic       brk;        // 6: force line low
    logic       spare;      // 5: stored, readable, no effect
    logic       par_even;   // 4: 1 even, 0 odd
    logic       par_en;     // 3: parity bit present
    logic       long_stop;  // 2: extended stop
    logic [1:0] wlen;       // 1:0: data bits minus five
  } fmt_reg_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       long_stop;
    logic       par_en;
    logic       par_even;
  } frame_fmt_t;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  function automatic int word_bits(input logic [1:0] wlen);
    return 5 + int'(wlen);
  endfunction

  // Stop duration in half-bit units
  function automatic int stop_halves(input logic [1:0] wlen, input logic long_stop);
    if (!long_stop) return 2;
    return (wlen == 2'b00) ? 3 : 4;
  endfunction

  function automatic logic parity_of(input logic [BYTE_W-1:0] d,
                                     input logic [1:0] wlen,
                                     input logic even);
    logic p;
    p = 1'b0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i < word_bits(wlen)) p = p ^ d[i];
    end
    return even ? p : ~p;
  endfunction

endpackage

// File: rtl/sft_tick_gen.sv
module sft_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == divisor - DIV_W'(1));
  assign tick   = (divisor != '0) && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || divisor == '0 || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/sft_regs.sv
module sft_regs
  import sft_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  output logic [BYTE_W-1:0] rdata,
  input  logic              take,
  output fmt_reg_t          fmt,
  output logic [DIV_W-1:0]  divisor,
  output logic              div_wr,
  output logic              hold_wr,
  output logic [BYTE_W-1:0] hold_data,
  output logic              hold_full
);

  localparam logic [ADDR_W-1:0] OFS_LO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_FMT = ADDR_W'(3);

  logic [BYTE_W-1:0] div_lo_q, div_hi_q;
  logic              lo_wr, hi_wr, fmt_wr;

  assign lo_wr   = wr && (addr == OFS_LO) && fmt.bank_div;
  assign hi_wr   = wr && (addr == OFS_HI) && fmt.bank_div;
  assign hold_wr = wr && (addr == OFS_LO) && !fmt.bank_div;
  assign fmt_wr  = wr && (addr == OFS_FMT);
  assign div_wr  = lo_wr || hi_wr;
  assign divisor = {div_hi_q, div_lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt      <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      if (fmt_wr) fmt      <= fmt_reg_t'(wdata);
      if (lo_wr)  div_lo_q <= wdata;
      if (hi_wr)  div_hi_q <= wdata;
    end
  end

  // Holding register: a write in the transfer cycle wins the flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else if (hold_wr) begin
      hold_data <= wdata;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFS_LO:  rdata = fmt.bank_div ? div_lo_q : '0;
        OFS_HI:  rdata = fmt.bank_div ? div_hi_q : '0;
        OFS_FMT: rdata = fmt;
        default: rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
  import sft_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [BYTE_W-1:0] hold_data,
  input  frame_fmt_t        fmt_in,
  output logic              take,
  output logic              line_bit,
  output phase_t            phase,
  output logic              bit_done
);

  localparam int HALF  = OVS / 2;
  localparam int CNT_W = $clog2(2 * OVS) + 1;

  logic [BYTE_W-1:0] sh_q;
  logic [2:0]        idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  dur;
  logic [1:0]        wl_q;
  logic              long_q, pe_q, par_q;
  logic              last_data;

  always_comb begin
    if (phase == PH_STOP) dur = CNT_W'(stop_halves(wl_q, long_q) * HALF);
    else                  dur = CNT_W'(OVS);
  end

  assign take      = (phase == PH_IDLE) && hold_full;
  assign bit_done  = tick && (phase != PH_IDLE) && (cnt_q == dur - CNT_W'(1));
  assign last_data = (idx_q == 3'(word_bits(wl_q) - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      sh_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      wl_q   <= '0;
      long_q <= 1'b0;
      pe_q   <= 1'b0;
      par_q  <= 1'b0;
    end else if (take) begin
      phase  <= PH_START;
      sh_q   <= hold_data;
      idx_q  <= '0;
      cnt_q  <= '0;
      wl_q   <= fmt_in.wlen;
      long_q <= fmt_in.long_stop;
      pe_q   <= fmt_in.par_en;
      par_q  <= parity_of(hold_data, fmt_in.wlen, fmt_in.par_even);
    end else if (bit_done) begin
      cnt_q <= '0;
      unique case (phase)
        PH_START: phase <= PH_DATA;
        PH_DATA: begin
          if (last_data) begin
            phase <= pe_q ? PH_PAR : PH_STOP;
          end else begin
            idx_q <= idx_q + 3'd1;
            sh_q  <= sh_q >> 1;
          end
        end
        PH_PAR:  phase <= PH_STOP;
        PH_STOP: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end else if (tick && phase != PH_IDLE) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    unique case (phase)
      PH_START: line_bit = 1'b0;
      PH_DATA:  line_bit = sh_q[0];
      PH_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              thr_empty,
  output logic              tx_line
);

  fmt_reg_t          fmt;
  frame_fmt_t        ffmt;
  logic [DIV_W-1:0]  divisor;
  logic              div_wr, hold_wr, hold_full, take, tick, line_bit, bit_done;
  logic              brk_on;
  logic [BYTE_W-1:0] hold_data;
  phase_t            phase;

  sft_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .wr(reg_wr), .rd(reg_rd), .rdata(reg_rdata), .take(take),
    .fmt(fmt), .divisor(divisor), .div_wr(div_wr), .hold_wr(hold_wr),
    .hold_data(hold_data), .hold_full(hold_full)
  );

  sft_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .restart(div_wr), .tick(tick)
  );

  assign ffmt = '{wlen: fmt.wlen, long_stop: fmt.long_stop,
                  par_en: fmt.par_en, par_even: fmt.par_even};

  sft_shifter #(.OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold_full(hold_full),
    .hold_data(hold_data), .fmt_in(ffmt), .take(take), .line_bit(line_bit),
    .phase(phase), .bit_done(bit_done)
  );

  assign brk_on    = fmt.brk;
  assign thr_empty = !hold_full;
  assign tx_line   = brk_on ? 1'b0 : line_bit;

endmodule

// File: rtl/sft_checker.sv
module sft_checker
  import sft_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tx_line,
  input logic             thr_empty,
  input logic             brk_on,
  input logic             take,
  input logic             hold_wr,
  input logic             tick,
  input logic             bit_done,
  input logic [DIV_W-1:0] divisor,
  input phase_t           phase
);

  AST_BREAK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk_on |-> !tx_line);                                          // R6
  AST_IDLE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !brk_on) |-> tx_line);                    // R2
  AST_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_START) |-> !tx_line);                             // R2
  AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STOP && !brk_on) |-> tx_line);                    // R4
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hold_wr) |=> thr_empty);                             // R10
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> !thr_empty);                                       // R10
  AST_NO_TICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |-> !tick);                                    // R9
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !take) |=> $stable(phase));                          // R9
  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (phase == PH_START));                                 // R2
  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |-> tick);                                            // R9

endmodule

bind serial_frame_tx sft_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_line(tx_line), .thr_empty(thr_empty),
  .brk_on(brk_on), .take(take), .hold_wr(hold_wr), .tick(tick),
  .bit_done(bit_done), .divisor(divisor), .phase(phase)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       thr_empty;
  logic       tx_line;

  int  vectors = 0;
  int  miscompares = 0;
  int  cyc = 0;
  int  bitc = 16;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .thr_empty(thr_empty), .tx_line(tx_line)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_divisor(input logic [15:0] dv, input logic [7:0] fmt_after);
    reg_write(3, 8'h80);
    reg_write(0, dv[7:0]);
    reg_write(1, dv[15:8]);
    reg_write(3, fmt_after);
  endtask

  // Capture one frame; entry at a negedge, t0 is the first negedge with line low
  task automatic grab(input logic [7:0] fmt_v, input logic [7:0] d, output int t0);
    int  nb, guard;
    bit  p;
    nb = 5 + int'(fmt_v[1:0]);
    guard = 0;
    t0 = 0;
    while (tx_line !== 1'b0) begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        chk(1'b0, "R2 start bit never seen", 1, 0);
        return;
      end
    end
    t0 = cyc;
    repeat (bitc / 2) @(negedge clk);
    chk(tx_line === 1'b0, "R2 start bit", int'(tx_line), 0);
    p = 1'b0;
    for (int k = 0; k < nb; k++) begin
      repeat (bitc) @(negedge clk);
      chk(tx_line === d[k], $sformatf("R3 data bit %0d", k), int'(tx_line), int'(d[k]));
      p ^= d[k];
    end
    if (fmt_v[3]) begin
      repeat (bitc) @(negedge clk);
      p = fmt_v[4] ? p : ~p;
      chk(tx_line === p, "R5 parity bit", int'(tx_line), int'(p));
    end
    repeat (bitc) @(negedge clk);
    chk(tx_line === 1'b1, "R4 stop bit level", int'(tx_line), 1);
  endtask

  task automatic send_pair(input logic [7:0] fmt_v, input logic [7:0] b0,
                           input logic [7:0] b1, input bit collide);
    int nb, pe, stop_t, d, ta, tb;
    nb = 5 + int'(fmt_v[1:0]);
    pe = int'(fmt_v[3]);
    stop_t = fmt_v[2] ? ((fmt_v[1:0] == 2'b00) ? 24 : 32) : 16;
    d = 16 * (1 + nb + pe) + stop_t;
    reg_write(3, fmt_v);
    if (collide) begin
      @(negedge clk);
      reg_addr = 3'd0; reg_wdata = b0; reg_wr = 1'b1;
      @(negedge clk);
      reg_wdata = b1;
      @(negedge clk);
      reg_wr = 1'b0;
      chk(thr_empty === 1'b0, "R10 write on transfer edge keeps flag low", int'(thr_empty), 0);
      grab(fmt_v, b0, ta);
      grab(fmt_v, b1, tb);
    end else begin
      reg_write(0, b0);
      fork
        begin
          while (thr_empty !== 1'b1) @(negedge clk);
          chk(1'b1, "R10 flag rises after transfer", 1, 1);
          reg_write(0, b1);
        end
        begin
          grab(fmt_v, b0, ta);
          grab(fmt_v, b1, tb);
        end
      join
    end
    chk(tb - ta == d + 1, "R11 start-to-start spacing (R4 stop length)", tb - ta, d + 1);
    repeat (48) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int         t;
    bit         stayed;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_line === 1'b1, "R1 line idle after reset", int'(tx_line), 1);
    chk(thr_empty === 1'b1, "R1 flag after reset", int'(thr_empty), 1);
    reg_read(3, rv);
    chk(rv == 8'h00, "R1 format register reset", rv, 0);
    reg_write(3, 8'h80);
    reg_read(0, rv);
    chk(rv == 8'h00, "R1 divisor low reset", rv, 0);
    reg_read(1, rv);
    chk(rv == 8'h00, "R1 divisor high reset", rv, 0);

    // R8 divisor bank access, writes to offset 0 do not reach the holding register
    reg_write(0, 8'h01);
    reg_write(1, 8'h00);
    chk(thr_empty === 1'b1, "R8 divisor write leaves flag", int'(thr_empty), 1);
    reg_read(0, rv);
    chk(rv == 8'h01, "R8 divisor low readback", rv, 1);
    reg_read(1, rv);
    chk(rv == 8'h00, "R8 divisor high readback", rv, 0);
    reg_write(3, 8'h00);
    reg_read(0, rv);
    chk(rv == 8'h00, "R8 offset 0 reads 0 with bank bit clear", rv, 0);
    stayed = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (tx_line !== 1'b1) stayed = 1'b0;
    end
    chk(stayed, "R8 no frame from divisor write", int'(stayed), 1);

    // Sweep every format with a byte pair
    for (int f = 0; f < 32; f++) begin
      logic [7:0] b0;
      b0 = 8'((f * 37 + 11) & 8'hff);
      send_pair(8'(f), b0, ~b0, 1'b0);
    end

    // R10 write coinciding with transfer
    send_pair(8'h03, 8'hA6, 8'h59, 1'b1);
    send_pair(8'h1C, 8'h0F, 8'h13, 1'b1);

    // R6 / R7 break and readback
    reg_write(3, 8'h63);
    chk(tx_line === 1'b0, "R6 break drives line low", int'(tx_line), 0);
    reg_read(3, rv);
    chk(rv == 8'h63, "R7 format readback", rv, 8'h63);
    reg_write(0, 8'hFF);
    stayed = 1'b1;
    repeat (250) begin
      @(negedge clk);
      if (tx_line !== 1'b0) stayed = 1'b0;
    end
    chk(stayed, "R6 line low during frame under break", int'(stayed), 1);
    chk(thr_empty === 1'b1, "R6 frame advanced under break", int'(thr_empty), 1);
    reg_write(3, 8'h03);
    chk(tx_line === 1'b1, "R6 line released", int'(tx_line), 1);
    reg_read(3, rv);
    chk(rv == 8'h03, "R7 format readback after clear", rv, 3);

    // R9 slower rate, divisor 5
    set_divisor(16'd5, 8'h03);
    bitc = 80;
    reg_write(0, 8'hA5);
    grab(8'h03, 8'hA5, t);
    repeat (200) @(negedge clk);

    // R9 divisor 0 freezes the line
    set_divisor(16'd0, 8'h03);
    reg_write(0, 8'h55);
    @(negedge clk);
    stayed = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (tx_line !== 1'b0) stayed = 1'b0;
    end
    chk(stayed, "R9 divisor 0 holds start bit", int'(stayed), 1);
    chk(thr_empty === 1'b1, "R10 byte moved without ticks", int'(thr_empty), 1);
    set_divisor(16'd1, 8'h03);
    bitc = 16;
    repeat (400) @(negedge clk);
    chk(tx_line === 1'b1, "R9 frame completes after restart", int'(tx_line), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule